// File: doc/BRIEF.md
# Clock Fanout Output-Control Serial Slave

This block is the control slave of a clock fanout buffer. It watches the two-wire serial bus through oversampled SCL and SDA inputs and holds three 8-bit registers whose bits enable the individual clock outputs. It answers on an open-drain SDA pull-down. A master sets a register either with a single random-access transfer or with a block write. A block write carries a byte count and fills the registers in order, starting at register 0. A master reads back through a repeated START. The register bits, gated by an active-low global output-enable pin, become a per-output drive enable and a per-output high-impedance request.

The device address is a parameter. Address bit 2 is not compared, so two bus addresses reach the same slave. A register index is a full byte. An index above 2 reads as zero, and a write to such an index changes nothing.

Top module: `clkfan_ctl_slave`

## Requirements
- R1: After reset all three registers hold 0xFF, so every `drive_en_o` bit is 1 when `oe_ni` is high and every register reads back 0xFF.
- R2: The slave acknowledges an address byte whose upper 7 bits equal `DEV_ADDR` when bit 2 of the address is ignored. On any other address it gives no ACK and leaves SDA alone until the next START.
- R3: In a write, a command byte with bit 7 = 0 is the register index. The slave ACKs the index and exactly one data byte, then stores that byte at the index. A further data byte in the same transfer is not acknowledged.
- R4: After an index is set, a repeated START with the read bit (address LSB = 1) returns the indexed register MSB first. Each master ACK advances the index and sends the next register. A master NACK ends the read with SDA released.
- R5: A command byte with bit 7 = 1 starts a block write. The next byte is a count N. The following N data bytes are acknowledged and stored in registers 0, 1, 2 in order. Byte N+1 is not acknowledged.
- R6: In a block write, data bytes that fall beyond register 2 are acknowledged and discarded.
- R7: A read at an index above 2 returns 0x00. A write to an index above 2 leaves all registers unchanged.
- R8: Output i is controlled by bit (i mod 8) of register (i div 8). Registers 0 and 1 drive outputs 0 to 15, and register 2 bits 0 and 1 drive outputs 16 and 17.
- R9: With `oe_ni` low, every `drive_en_o` bit is 0 and every `hiz_o` bit is 1 whatever the registers hold. With `oe_ni` high, `hiz_o` is 0 and `drive_en_o` follows the registers.
- R10: A STOP at any point releases SDA and returns the slave to idle. A data byte cut short by the STOP is not stored, and the next transfer works normally.
- R11: A falling SDA edge while SCL is high is taken as START and a rising one as STOP. The slave changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| oe_ni | input | 1 | Global output enable, active low |
| sda_pd_o | output | 1 | Pull SDA low when 1 (open-drain driver control) |
| drive_en_o | output | 18 | Per-output clock drive enable |
| hiz_o | output | 18 | Per-output tristate request |

## Verification
A register write landing from the serial side and the global enable forcing tristate can act on the outputs in the same cycle. The bench holds `oe_ni` low while a full random write completes. It checks that the outputs stay tristated and disabled throughout, then raises the pin and expects the newly written value at once. A second overlap is a STOP arriving inside a data byte while the byte engine is mid-shift. The bench judges it by reading the register back unchanged and by a fresh transfer being acknowledged.

// File: rtl/clkfan_ctl_pkg.sv
package clkfan_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_DATA,
    ST_ACK,
    ST_TX,
    ST_MACK
  } slv_st_e;

  // address bit 2 is not compared
  localparam logic [6:0] ADDR_CMP_MASK = 7'h7B;
endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_q, sda_q;
  logic       scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_p <= scl_q[1];
      sda_p <= sda_q[1];
    end
  end

  assign sda_s_o    = sda_q[1];
  assign scl_rise_o = scl_q[1] & ~scl_p;
  assign scl_fall_o = ~scl_q[1] & scl_p;
  assign start_o    = scl_q[1] & scl_p & sda_p & ~sda_q[1];
  assign stop_o     = scl_q[1] & scl_p & ~sda_p & sda_q[1];
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank #(
  parameter int N_OUT = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic [7:0]       rd_idx_i,
  output logic [7:0]       rd_data_o,
  output logic [N_OUT-1:0] bits_o
);
  localparam int         N_REG   = (N_OUT + 7) / 8;
  localparam int         IDXW    = (N_REG > 1) ? $clog2(N_REG) : 1;
  localparam logic [7:0] N_REG_B = 8'(N_REG);

  logic [N_REG-1:0][7:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < N_REG; r++) regs_q[r] <= 8'hFF;
    end else if (wr_en_i && (wr_idx_i < N_REG_B)) begin
      regs_q[wr_idx_i[IDXW-1:0]] <= wr_data_i;
    end
  end

  assign rd_data_o = (rd_idx_i < N_REG_B) ? regs_q[rd_idx_i[IDXW-1:0]] : 8'h00;

  for (genvar g = 0; g < N_OUT; g++) begin : g_map
    assign bits_o[g] = regs_q[g / 8][g % 8];
  end

  // R7
  oob_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i >= N_REG_B) |=> $stable(regs_q));

  // R3
  in_range_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i < N_REG_B) |=>
      regs_q[$past(wr_idx_i[IDXW-1:0])] == $past(wr_data_i));
endmodule

// File: rtl/slv_ctrl_fsm.sv
module slv_ctrl_fsm
  import clkfan_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_pd_o,
  output logic       wr_en_o,
  output logic [7:0] wr_idx_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] rd_idx_o
);
  slv_st_e    st_q, nxt_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q, tx_q, ptr_q, left_q;
  logic       drv_q, more_q;
  logic       byte_end, addr_hit;

  assign byte_end = scl_fall_i && (bit_q == 4'd8);
  assign addr_hit = (sh_q[7:1] & ADDR_CMP_MASK) == (DEV_ADDR & ADDR_CMP_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      nxt_q  <= ST_IDLE;
      bit_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      left_q <= '0;
      drv_q  <= 1'b0;
      more_q <= 1'b0;
    end else if (start_i) begin
      st_q  <= ST_ADDR;
      bit_q <= '0;
      drv_q <= 1'b0;
    end else if (stop_i) begin
      st_q  <= ST_IDLE;
      drv_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_CMD, ST_CNT, ST_DATA: begin
          if (scl_rise_i && bit_q < 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_s_i};
            bit_q <= bit_q + 4'd1;
          end else if (byte_end) begin
            bit_q <= '0;
            st_q  <= ST_ACK;
            drv_q <= 1'b1;
            if (st_q == ST_ADDR) begin
              nxt_q <= sh_q[0] ? ST_TX : ST_CMD;
              if (!addr_hit) begin
                st_q  <= ST_IDLE;
                drv_q <= 1'b0;
              end
            end else if (st_q == ST_CMD) begin
              if (sh_q[7]) begin
                ptr_q <= '0;
                nxt_q <= ST_CNT;
              end else begin
                ptr_q  <= sh_q;
                left_q <= 8'd1;
                nxt_q  <= ST_DATA;
              end
            end else if (st_q == ST_CNT) begin
              left_q <= sh_q;
              nxt_q  <= ST_DATA;
            end else begin
              nxt_q <= ST_DATA;
              if (left_q != '0) begin
                ptr_q  <= ptr_q + 8'd1;
                left_q <= left_q - 8'd1;
              end else begin
                st_q  <= ST_IDLE;
                drv_q <= 1'b0;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            if (nxt_q == ST_TX) begin
              tx_q  <= rd_data_i;
              drv_q <= ~rd_data_i[7];
            end else begin
              drv_q <= 1'b0;
            end
            st_q <= nxt_q;
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            bit_q <= bit_q + 4'd1;
          end else if (scl_fall_i) begin
            if (bit_q == 4'd8) begin
              drv_q <= 1'b0;
              st_q  <= ST_MACK;
            end else begin
              drv_q <= ~tx_q[3'd7 - bit_q[2:0]];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            more_q <= ~sda_s_i;
            if (!sda_s_i) ptr_q <= ptr_q + 8'd1;
          end else if (scl_fall_i) begin
            bit_q <= '0;
            if (more_q) begin
              tx_q  <= rd_data_i;
              drv_q <= ~rd_data_i[7];
              st_q  <= ST_TX;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pd_o  = drv_q;
  assign rd_idx_o  = ptr_q;
  assign wr_idx_o  = ptr_q;
  assign wr_data_o = sh_q;
  assign wr_en_o   = (st_q == ST_DATA) && byte_end && (left_q != '0) && !start_i && !stop_i;

  // R10
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!sda_pd_o && st_q == ST_IDLE));

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_pd_o);

  // R11
  sda_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_fall_i && !start_i && !stop_i) |=> $stable(sda_pd_o));
endmodule

// File: rtl/clkfan_ctl_slave.sv
module clkfan_ctl_slave #(
  parameter int         N_OUT    = 18,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             oe_ni,
  output logic             sda_pd_o,
  output logic [N_OUT-1:0] drive_en_o,
  output logic [N_OUT-1:0] hiz_o
);
  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [7:0]       wr_idx, wr_data, rd_idx, rd_data;
  logic [N_OUT-1:0] ctl_bits;

  bus_line_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  slv_ctrl_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .rd_data_i  (rd_data),
    .sda_pd_o   (sda_pd_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .rd_idx_o   (rd_idx)
  );

  ctl_reg_bank #(.N_OUT(N_OUT)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .bits_o    (ctl_bits)
  );

  assign drive_en_o = oe_ni ? ctl_bits : '0;
  assign hiz_o      = {N_OUT{~oe_ni}};
endmodule

// File: tb/clkfan_ctl_slave_tb_top.sv
module clkfan_ctl_slave_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam int         Q          = 5;
  localparam int         N_OUT      = 18;
  localparam logic [6:0] DEV        = 7'h69;
  // {index, data written, expected readback}
  localparam logic [23:0] WR_VEC [0:5] = '{
    24'h00_A5_A5, 24'h01_3C_3C, 24'h02_C2_C2,
    24'h05_77_00, 24'h02_01_01, 24'h7F_00_00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, oe_n = 1'b1;
  logic sda_pd;
  logic sda_bus;
  logic [N_OUT-1:0] drive_en, hiz;
  logic [7:0] mreg [0:2];
  int checks = 0, errors = 0;
  int hold_viol = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_pd;

  clkfan_ctl_slave #(.N_OUT(N_OUT), .DEV_ADDR(DEV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .oe_ni(oe_n),
    .sda_pd_o(sda_pd), .drive_en_o(drive_en), .hiz_o(hiz)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(logic [7:0] b, output logic ack);
    logic nak;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(nak);
    ack = ~nak;
  endtask

  task automatic rd_byte(logic ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) recv_bit(b[i]);
    send_bit(~ack);
  endtask

  task automatic wr_reg(logic [6:0] a, logic [7:0] idx, logic [7:0] d, output logic [2:0] acks);
    bus_start();
    wr_byte({a, 1'b0}, acks[2]);
    wr_byte(idx, acks[1]);
    wr_byte(d, acks[0]);
    bus_stop();
  endtask

  task automatic rd_reg(logic [7:0] idx, output logic [7:0] d);
    logic a;
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(idx, a);
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b0, d);
    bus_stop();
  endtask

  function automatic logic [N_OUT-1:0] exp_bits();
    return {mreg[2][1:0], mreg[1], mreg[0]};
  endfunction

  // R11: slave pull-down must not move while SCL is high
  logic pd_prev = 1'b0, scl_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_prev && (sda_pd != pd_prev)) hold_viol++;
    pd_prev  <= sda_pd;
    scl_prev <= scl_m;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] d;
    logic a;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    for (int r = 0; r < 3; r++) mreg[r] = 8'hFF;

    // R1 reset state
    chk("R1 drive_en", 32'(drive_en), 32'(exp_bits()));
    chk("R1 hiz", 32'(hiz), 32'h0);
    chk("R1 sda_pd", 32'(sda_pd), 32'h0);
    for (int r = 0; r < 3; r++) begin
      rd_reg(8'(r), d);
      chk("R1 readback", 32'(d), 32'hFF);
    end

    // R3 R7 R8 table walk
    for (int i = 0; i < 6; i++) begin
      wr_reg(DEV, WR_VEC[i][23:16], WR_VEC[i][15:8], acks);
      if (WR_VEC[i][23:16] < 8'd3) mreg[WR_VEC[i][23:16]] = WR_VEC[i][15:8];
      chk("R3 write acks", 32'(acks), 32'h7);
      rd_reg(WR_VEC[i][23:16], d);
      chk("R3/R7 readback", 32'(d), 32'(WR_VEC[i][7:0]));
      chk("R8 output map", 32'(drive_en), 32'(exp_bits()));
    end

    // R2 alternate address with bit 2 flipped
    wr_reg(DEV ^ 7'h04, 8'h00, 8'h5A, acks);
    mreg[0] = 8'h5A;
    chk("R2 alt address acks", 32'(acks), 32'h7);
    rd_reg(8'h00, d);
    chk("R2 alt address write", 32'(d), 32'h5A);

    // R2 mismatched address
    wr_reg(DEV ^ 7'h01, 8'h00, 8'h00, acks);
    chk("R2 mismatch no ack", 32'(acks), 32'h0);
    rd_reg(8'h00, d);
    chk("R2 mismatch ignored", 32'(d), 32'h5A);

    // R3 surplus byte in random write
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h01, a);
    wr_byte(8'h11, a);
    chk("R3 data ack", 32'(a), 32'h1);
    wr_byte(8'h22, a);
    chk("R3 extra byte nack", 32'(a), 32'h0);
    bus_stop();
    mreg[1] = 8'h11;
    rd_reg(8'h01, d);
    chk("R3 extra byte dropped", 32'(d), 32'h11);

    // R5 block write, count 3
    bus_start();
    wr_byte({DEV, 1'b0}, acks[0]);
    wr_byte(8'h80, acks[1]);
    wr_byte(8'd3, acks[2]);
    chk("R5 header acks", 32'(acks), 32'h7);
    wr_byte(8'h0F, acks[0]);
    wr_byte(8'hF0, acks[1]);
    wr_byte(8'h03, acks[2]);
    chk("R5 data acks", 32'(acks), 32'h7);
    wr_byte(8'hEE, a);
    chk("R5 past count nack", 32'(a), 32'h0);
    bus_stop();
    mreg[0] = 8'h0F; mreg[1] = 8'hF0; mreg[2] = 8'h03;
    chk("R5 block outputs", 32'(drive_en), 32'(exp_bits()));

    // R6 block write, count 5
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h80, a);
    wr_byte(8'd5, a);
    acks = 3'b111;
    for (int i = 1; i <= 5; i++) begin
      wr_byte(8'(i), a);
      if (!a) acks = 3'b000;
    end
    chk("R6 overflow bytes acked", 32'(acks), 32'h7);
    bus_stop();
    mreg[0] = 8'h01; mreg[1] = 8'h02; mreg[2] = 8'h03;
    chk("R6 registers", 32'(drive_en), 32'(exp_bits()));

    // R4 R7 sequential read
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h00, a);
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    chk("R4 read address ack", 32'(a), 32'h1);
    for (int i = 0; i < 4; i++) begin
      rd_byte(i < 3, d);
      chk("R4/R7 sequential read", 32'(d), (i < 3) ? 32'(mreg[i]) : 32'h0);
    end
    chk("R4 released after nack", 32'(sda_pd), 32'h0);
    bus_stop();

    // R10 stop inside a data byte
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h00, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    chk("R10 sda released", 32'(sda_pd), 32'h0);
    rd_reg(8'h00, d);
    chk("R10 partial byte dropped", 32'(d), 32'(mreg[0]));
    wr_reg(DEV, 8'h00, 8'hC3, acks);
    mreg[0] = 8'hC3;
    chk("R10 next transfer acks", 32'(acks), 32'h7);

    // R9 global enable overlapping a write
    oe_n = 1'b0;
    tick(2);
    chk("R9 drive off", 32'(drive_en), 32'h0);
    chk("R9 all tristate", 32'(hiz), 32'h3FFFF);
    wr_reg(DEV, 8'h01, 8'h99, acks);
    mreg[1] = 8'h99;
    chk("R9 drive off after write", 32'(drive_en), 32'h0);
    oe_n = 1'b1;
    tick(1);
    chk("R9 enable restored", 32'(drive_en), 32'(exp_bits()));
    chk("R9 tristate cleared", 32'(hiz), 32'h0);

    chk("R11 pull-down stable while SCL high", 32'(hold_viol), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule